// File: doc/BRIEF.md
# Periodic Counter Snapshot Ring Writer

This block keeps a small bank of aggregating event counters. When a programmable period elapses, it writes one report holding their values into a circular buffer in memory through a one-word-per-cycle write port. Software sets up the buffer with three registers: the head (read) position, the base address, and a status word. The status word carries the tail (write) position, the size code and three sticky error flags. A fourth register, the control word, enables counting and reporting. It also selects the report format and the period exponent, and can limit reporting to a single context ID.

The period is set only as a power of two: `BASE_CYC * 2^(exp+1)` clock cycles. `BASE_CYC` is the clock-cycle equivalent of the 80 ns unit, so exponent 0 gives two base units. The tail moves in whole 64-byte steps and is never wrapped to the buffer size. The consumer computes the fill level as `(tail - head) & (size - 1)`. A report that would run into unread data is dropped, and the drop is flagged.

Top module: `snap_ring_writer`

## Requirements
- R1: After reset, all four registers read 0, `mem_we` is 0 and `mem_space` is 0.
- R2: With enable (control bit 0) and timer enable (control bit 5) set, a report starts every `BASE_CYC*2^(exp+1)` cycles, where exp is control bits 11:6. The timestamp in the header differs by the same amount between consecutive reports.
- R3: The report length is set by the format code in control bits 4:2: codes 0, 4 and 7 give 64 bytes; codes 1, 2 and 6 give 128; code 3 gives 192; code 5 gives 256. Word 0 is the header {report ID[7:0], timestamp[23:0]}. The ID starts at 0 after reset and increases by one for each written report. Words 1..NUM_CTR hold the counters in index order, and every remaining word is 0.
- R4: Word i of a report goes to `base + ((tail + 4i) & (size-1))`. When the report completes, the tail (status bits 31:6) advances by the report length without being wrapped to the buffer size.
- R5: A report is written only if `((tail-head)&(size-1)) + length < size`. Otherwise nothing is written, the tail is unchanged, and status bits 0 (lost) and 1 (buffer overflow) are set.
- R6: Status bits 2:0 are sticky. A write to the status register ANDs them with the written bits 2:0, so 0 clears a flag and 1 keeps it.
- R7: A counter that increments past its all-ones value wraps to 0 and sets status bit 2.
- R8: With per-context mode (control bit 1) set, a period produces a report only when `cur_ctx` equals control bits 31:12. A mismatch drops the report silently, without setting any flag.
- R9: After enable is cleared, a report already in progress completes in full, and no further report starts.
- R10: A period that expires while a report is still being written sets only status bit 0.
- R11: The head register keeps bits 31:6 and bit 0, and bits 5:1 read as 0. Bit 0 drives `mem_space`.
- R12: With timer enable clear, no report is written even though counting continues.
- R13: The buffer size is `2^(MIN_BUF_LOG2+n)` bytes, where n is status bits 5:3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 status/tail, 2 head, 3 base |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| cnt_inc | input | NUM_CTR | Per-counter increment pulses |
| cur_ctx | input | 20 | ID of the context currently running |
| mem_we | output | 1 | Memory word write strobe |
| mem_addr | output | 32 | Byte address of the word being written |
| mem_wdata | output | 32 | Word being written |
| mem_space | output | 1 | Address-space select copied from head bit 0 |

## Verification
The hardest situations to reach are the ring edge cases. One is a report that straddles the end of the buffer; another is the rejection of a report because it would overrun unread data. The bench reaches both with a small minimum buffer size. It places the head and the tail directly through the status and head registers, just short of the end, and picks format codes whose lengths either wrap or exactly exceed the free space. A period much longer than one report keeps the outcome of each period separate. Busy collisions come from a deliberately short period.

// File: rtl/snap_pkg.sv
package snap_pkg;

    typedef struct packed {
        logic [19:0] ctx;
        logic [5:0]  exp;
        logic        ten;
        logic [2:0]  fmt;
        logic        pctx;
        logic        en;
    } ctl_t;

    typedef enum logic {S_IDLE, S_WRITE} wr_state_t;

    localparam logic [1:0] REG_CTL  = 2'd0;
    localparam logic [1:0] REG_STAT = 2'd1;
    localparam logic [1:0] REG_HEAD = 2'd2;
    localparam logic [1:0] REG_BASE = 2'd3;

    // report length in 32-bit words for a format code
    function automatic logic [6:0] fmt_words(input logic [2:0] f);
        case (f)
            3'd1, 3'd2, 3'd6: fmt_words = 7'd32;
            3'd3:             fmt_words = 7'd48;
            3'd5:             fmt_words = 7'd64;
            default:          fmt_words = 7'd16;
        endcase
    endfunction

    // mask with exp+1 low bits set
    function automatic logic [63:0] period_mask(input logic [5:0] e);
        period_mask = ~(64'hFFFF_FFFF_FFFF_FFFF << (7'(e) + 7'd1));
    endfunction

endpackage

// File: rtl/snap_timer.sv
module snap_timer import snap_pkg::*; #(
    parameter int BASE_CYC = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic [5:0] exp,
    output logic       fire
);
    localparam int PW = (BASE_CYC > 1) ? $clog2(BASE_CYC) : 1;

    logic [PW-1:0] pre_q;
    logic [63:0]   per_q;
    logic          unit;
    logic [63:0]   mask;

    assign unit = (pre_q == PW'(BASE_CYC - 1));
    assign mask = period_mask(exp);
    assign fire = run && unit && (per_q == mask);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pre_q <= '0;
            per_q <= '0;
        end else if (unit) begin
            pre_q <= '0;
            per_q <= (per_q == mask) ? 64'd0 : per_q + 64'd1;
        end else begin
            pre_q <= pre_q + PW'(1);
        end
    end
endmodule

// File: rtl/snap_counters.sv
module snap_counters #(
    parameter int NUM_CTR = 8,
    parameter int CTR_W   = 32
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            en,
    input  logic [NUM_CTR-1:0]              inc,
    output logic [NUM_CTR-1:0][CTR_W-1:0]   vals,
    output logic                            wrap
);
    logic [NUM_CTR-1:0] wrap_v;

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
        assign wrap_v[i] = en && inc[i] && (&vals[i]);
        always_ff @(posedge clk) begin
            if (rst)
                vals[i] <= '0;
            else if (en && inc[i])
                vals[i] <= vals[i] + CTR_W'(1);
        end
    end

    assign wrap = |wrap_v;
endmodule

// File: rtl/snap_space.sv
module snap_space #(
    parameter int MIN_BUF_LOG2 = 17
) (
    input  logic [25:0] tail,
    input  logic [25:0] head,
    input  logic [2:0]  size_n,
    input  logic [6:0]  need_words,
    output logic [31:0] ring_mask,
    output logic        room_ok
);
    logic [32:0] size_b;
    logic [31:0] fill;

    assign size_b    = 33'd1 << (6'(MIN_BUF_LOG2) + 6'(size_n));
    assign ring_mask = size_b[31:0] - 32'd1;
    assign fill      = ({tail, 6'b0} - {head, 6'b0}) & ring_mask;
    assign room_ok   = ({1'b0, fill} + {24'b0, need_words, 2'b0}) < size_b;
endmodule

// File: rtl/snap_ring_writer.sv
module snap_ring_writer import snap_pkg::*; #(
    parameter int NUM_CTR      = 8,
    parameter int CTR_W        = 32,
    parameter int BASE_CYC     = 4,
    parameter int MIN_BUF_LOG2 = 17
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_we,
    input  logic [1:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic [NUM_CTR-1:0] cnt_inc,
    input  logic [19:0]        cur_ctx,
    output logic               mem_we,
    output logic [31:0]        mem_addr,
    output logic [31:0]        mem_wdata,
    output logic               mem_space
);
    ctl_t        ctl_q;
    logic [25:0] tail_q, head_q, base_q;
    logic        head_sel_q;
    logic [2:0]  size_n_q;
    logic [2:0]  sticky, sticky_d;
    wr_state_t   state_q;
    logic [5:0]  widx_q;
    logic [6:0]  rep_w_q;
    logic [7:0]  rep_id_q;
    logic [23:0] ts_q;
    logic [31:0] hdr_q;
    logic [NUM_CTR-1:0][CTR_W-1:0] snap_q, ctr_vals;
    logic        ctr_wrap, fire, room_ok, busy, gate, last_word;
    logic        accept, drop_full, drop_busy, wr_stat;
    logic [31:0] ring_mask;
    logic [6:0]  cur_words;

    snap_timer #(.BASE_CYC(BASE_CYC)) u_timer (
        .clk(clk), .rst(rst), .run(ctl_q.en && ctl_q.ten),
        .exp(ctl_q.exp), .fire(fire)
    );

    snap_counters #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W)) u_ctrs (
        .clk(clk), .rst(rst), .en(ctl_q.en), .inc(cnt_inc),
        .vals(ctr_vals), .wrap(ctr_wrap)
    );

    snap_space #(.MIN_BUF_LOG2(MIN_BUF_LOG2)) u_space (
        .tail(tail_q), .head(head_q), .size_n(size_n_q),
        .need_words(cur_words), .ring_mask(ring_mask), .room_ok(room_ok)
    );

    assign cur_words = fmt_words(ctl_q.fmt);
    assign busy      = (state_q == S_WRITE);
    assign gate      = !ctl_q.pctx || (cur_ctx == ctl_q.ctx);
    assign last_word = ({1'b0, widx_q} == rep_w_q - 7'd1);
    assign accept    = fire && gate && !busy && room_ok;
    assign drop_full = fire && gate && !busy && !room_ok;
    assign drop_busy = fire && gate && busy;
    assign wr_stat   = reg_we && (reg_addr == REG_STAT);

    always_comb begin
        sticky_d = wr_stat ? (sticky & reg_wdata[2:0]) : sticky;
        if (drop_full) sticky_d = sticky_d | 3'b011;
        if (drop_busy) sticky_d = sticky_d | 3'b001;
        if (ctr_wrap)  sticky_d = sticky_d | 3'b100;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q      <= '0;
            tail_q     <= '0;
            head_q     <= '0;
            base_q     <= '0;
            head_sel_q <= 1'b0;
            size_n_q   <= '0;
            sticky     <= '0;
            state_q    <= S_IDLE;
            widx_q     <= '0;
            rep_w_q    <= 7'd16;
            rep_id_q   <= '0;
            ts_q       <= '0;
            hdr_q      <= '0;
            snap_q     <= '0;
        end else begin
            ts_q   <= ts_q + 24'd1;
            sticky <= sticky_d;
            if (reg_we && reg_addr == REG_CTL) ctl_q <= ctl_t'(reg_wdata);
            if (reg_we && reg_addr == REG_HEAD) begin
                head_q     <= reg_wdata[31:6];
                head_sel_q <= reg_wdata[0];
            end
            if (reg_we && reg_addr == REG_BASE) base_q <= reg_wdata[31:6];
            if (wr_stat) size_n_q <= reg_wdata[5:3];
            if (busy && last_word)
                tail_q <= tail_q + 26'(rep_w_q[6:4]);
            else if (wr_stat)
                tail_q <= reg_wdata[31:6];
            if (accept) begin
                state_q  <= S_WRITE;
                widx_q   <= '0;
                rep_w_q  <= cur_words;
                hdr_q    <= {rep_id_q, ts_q};
                snap_q   <= ctr_vals;
                rep_id_q <= rep_id_q + 8'd1;
            end else if (busy) begin
                widx_q <= widx_q + 6'd1;
                if (last_word) state_q <= S_IDLE;
            end
        end
    end

    always_comb begin
        mem_wdata = '0;
        if (widx_q == 6'd0) mem_wdata = hdr_q;
        for (int i = 0; i < NUM_CTR; i++)
            if (widx_q == 6'(i + 1)) mem_wdata = 32'(snap_q[i]);
    end

    assign mem_we    = busy;
    assign mem_addr  = {base_q, 6'b0} +
                       (({tail_q, 6'b0} + {24'b0, widx_q, 2'b0}) & ring_mask);
    assign mem_space = head_sel_q;

    always_comb begin
        case (reg_addr)
            REG_CTL:  reg_rdata = ctl_q;
            REG_STAT: reg_rdata = {tail_q, size_n_q, sticky};
            REG_HEAD: reg_rdata = {head_q, 5'b0, head_sel_q};
            default:  reg_rdata = {base_q, 6'b0};
        endcase
    end
endmodule

// File: rtl/snap_ring_chk.sv
module snap_ring_chk (
    input logic        clk,
    input logic        rst,
    input logic        reg_we,
    input logic [1:0]  reg_addr,
    input logic        en,
    input logic        busy,
    input logic        mem_we,
    input logic [25:0] tail,
    input logic [2:0]  sticky
);
    AST_TAIL_STEP: assert property (@(posedge clk) disable iff (rst)
        ((tail != $past(tail)) && !$past(reg_we && reg_addr == 2'd1)) |->
        ((tail - $past(tail)) >= 26'd1 && (tail - $past(tail)) <= 26'd4)); // R4
    AST_OVF_WITH_LOST: assert property (@(posedge clk) disable iff (rst)
        $rose(sticky[1]) |-> sticky[0]); // R5
    AST_LOST_STICKY: assert property (@(posedge clk) disable iff (rst)
        $fell(sticky[0]) |-> $past(reg_we && reg_addr == 2'd1)); // R6
    AST_CTR_STICKY: assert property (@(posedge clk) disable iff (rst)
        $fell(sticky[2]) |-> $past(reg_we && reg_addr == 2'd1)); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!en && !busy) |=> !mem_we); // R9
endmodule

bind snap_ring_writer snap_ring_chk u_chk (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .en(ctl_q.en), .busy(busy), .mem_we(mem_we), .tail(tail_q),
    .sticky(sticky)
);

// File: tb/sim_snap_ring_writer.sv
module sim_snap_ring_writer;
    localparam int NC = 4;
    logic clk = 1'b0, rst = 1'b1;
    logic reg_we = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic [NC-1:0] cnt_inc = '0;
    logic [19:0] cur_ctx = '0;
    logic mem_we, mem_space;
    logic [31:0] mem_addr, mem_wdata;

    always #10 clk = ~clk;

    snap_ring_writer #(.NUM_CTR(NC), .CTR_W(8), .BASE_CYC(4), .MIN_BUF_LOG2(8)) u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cnt_inc(cnt_inc),
        .cur_ctx(cur_ctx), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_space(mem_space)
    );

    int checks = 0, errors = 0, cyc = 0, nstart = 0, nwords = 0;
    int start_cyc [0:63];
    logic [31:0] mem [0:1023];
    logic we_d = 1'b0;
    bit done = 0;

    always @(negedge clk) begin
        cyc++;
        if (mem_we) begin
            mem[mem_addr[11:2]] = mem_wdata;
            nwords++;
            if (!we_d && nstart < 64) begin
                start_cyc[nstart] = cyc;
                nstart++;
            end
        end
        we_d = mem_we;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [31:0] ctl(input bit en, input bit pc, input int fmt,
                                        input bit ten, input int e, input int cx);
        return {20'(cx), 6'(e), ten, 3'(fmt), pc, en};
    endfunction

    task automatic setup(input int head, input int tail, input int n);
        reg_wr(2, 32'(head));
        reg_wr(3, 32'h400);
        reg_wr(1, 32'(tail) | 32'(n << 3));
    endtask

    task automatic pulse(input int i, input int n);
        @(negedge clk);
        cnt_inc[i] = 1'b1;
        repeat (n) @(negedge clk);
        cnt_inc[i] = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (mem_we);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int a = 0; a < 4; a++) begin
            reg_rd(2'(a), d);
            chk("R1 register reset", d, 0);
        end
        chk("R1 mem_we reset", 32'(mem_we), 0);
        chk("R1 mem_space reset", 32'(mem_space), 0);
    endtask

    task automatic t_basic();
        logic [31:0] d;
        int s0, w0, b;
        bit padok;
        setup(0, 0, 0);
        reg_wr(0, ctl(1, 0, 0, 0, 0, 0));
        pulse(0, 3); pulse(1, 5); pulse(3, 7);
        s0 = nstart; w0 = nwords;
        reg_wr(0, ctl(1, 0, 0, 1, 2, 0));
        for (int k = 0; k < 200 && nstart < s0 + 2; k++) @(negedge clk);
        wait_idle();
        reg_wr(0, 0);
        repeat (40) @(negedge clk);
        chk("R2 two reports", 32'(nstart - s0), 2);
        chk("R2 period cycles", 32'(start_cyc[s0+1] - start_cyc[s0]), 32);
        chk("R3 words for format 0", 32'(nwords - w0), 32);
        b = 32'h400 >> 2;
        chk("R3 first id", 32'(mem[b][31:24]), 0);
        chk("R3 second id", 32'(mem[b+16][31:24]), 1);
        chk("R2 timestamp step", 32'((mem[b+16][23:0] - mem[b][23:0]) & 24'hFFFFFF), 32);
        chk("R3 ctr0", mem[b+1], 3);
        chk("R3 ctr1", mem[b+2], 5);
        chk("R3 ctr2", mem[b+3], 0);
        chk("R3 ctr3", mem[b+4], 7);
        padok = 1;
        for (int i = 5; i < 16; i++) if (mem[b+i] != 0) padok = 0;
        chk("R3 padding zero", 32'(padok), 1);
        reg_rd(1, d);
        chk("R4 tail after two reports", d & 32'hFFFF_FFC0, 128);
    endtask

    task automatic t_full();
        logic [31:0] d;
        int s0, w0;
        setup(0, 0, 0);
        s0 = nstart; w0 = nwords;
        reg_wr(0, ctl(1, 0, 3, 1, 3, 0));
        repeat (150) @(negedge clk);
        reg_wr(0, 0);
        wait_idle();
        chk("R3 words for format 3", 32'(nwords - w0), 48);
        chk("R5 only one report fits", 32'(nstart - s0), 1);
        reg_rd(1, d);
        chk("R4 tail after 192 bytes", d & 32'hFFFF_FFC0, 192);
        chk("R5 lost and overflow set", d & 32'h3, 3);
        reg_wr(1, 192 | 1);
        reg_rd(1, d);
        chk("R6 keep lost clear overflow", d & 32'h7, 1);
        chk("R6 tail written back", d & 32'hFFFF_FFC0, 192);
        reg_wr(1, 192);
        reg_rd(1, d);
        chk("R6 all clear", d & 32'h7, 0);
    endtask

    task automatic t_wrap();
        logic [31:0] d;
        int w0, b;
        for (int i = 0; i < 1024; i++) mem[i] = 32'hDEAD_BEEF;
        setup(192, 192, 0);
        w0 = nwords;
        reg_wr(0, ctl(1, 0, 1, 1, 3, 0));
        repeat (100) @(negedge clk);
        reg_wr(0, 0);
        wait_idle();
        b = 32'h400 >> 2;
        chk("R3 words for format 1", 32'(nwords - w0), 32);
        chk("R4 header at tail offset", 32'(mem[b+48][31:24]), 3);
        chk("R4 wrapped word at offset 0", mem[b], 0);
        chk("R4 offset 64 untouched", mem[b+16], 32'hDEAD_BEEF);
        reg_rd(1, d);
        chk("R4 tail not wrapped", d & 32'hFFFF_FFC0, 320);
    endtask

    task automatic t_ctx();
        logic [31:0] d;
        int s0;
        setup(0, 0, 3);
        cur_ctx = 20'h6;
        s0 = nstart;
        reg_wr(0, ctl(1, 1, 0, 1, 2, 5));
        repeat (120) @(negedge clk);
        chk("R8 mismatch no report", 32'(nstart - s0), 0);
        cur_ctx = 20'h5;
        repeat (40) @(negedge clk);
        chk("R8 match reports", 32'(nstart - s0 >= 1), 1);
        reg_wr(0, 0);
        wait_idle();
        cur_ctx = '0;
        reg_rd(1, d);
        chk("R8 mismatch sets no flag", d & 32'h7, 0);
    endtask

    task automatic t_busy();
        logic [31:0] d;
        setup(0, 0, 3);
        reg_wr(0, ctl(1, 0, 0, 1, 0, 0));
        repeat (40) @(negedge clk);
        reg_wr(0, 0);
        wait_idle();
        reg_rd(1, d);
        chk("R10 busy collision flags", d & 32'h7, 1);
        chk("R13 size code 3 kept", (d >> 3) & 32'h7, 3);
    endtask

    task automatic t_ctr();
        logic [31:0] d;
        int s0;
        setup(0, 0, 0);
        s0 = nstart;
        reg_wr(0, ctl(1, 0, 0, 0, 0, 0));
        repeat (200) @(negedge clk);
        chk("R12 no report without timer", 32'(nstart - s0), 0);
        reg_rd(1, d);
        chk("R7 no wrap yet", d & 32'h4, 0);
        pulse(0, 256);
        reg_rd(1, d);
        chk("R7 counter wrap flag", d & 32'h4, 4);
        reg_wr(0, 0);
    endtask

    task automatic t_disable();
        logic [31:0] d;
        int s0, w0;
        setup(0, 0, 3);
        s0 = nstart; w0 = nwords;
        reg_wr(0, ctl(1, 0, 6, 1, 2, 0));
        for (int k = 0; k < 200 && nstart == s0; k++) @(negedge clk);
        reg_wr(0, 0);
        repeat (150) @(negedge clk);
        chk("R9 one report", 32'(nstart - s0), 1);
        chk("R9 report completes", 32'(nwords - w0), 32);
        reg_rd(1, d);
        chk("R9 tail advanced", d & 32'hFFFF_FFC0, 128);
    endtask

    task automatic t_head();
        logic [31:0] d;
        reg_wr(2, 32'h1234_567F);
        reg_rd(2, d);
        chk("R11 head readback", d, 32'h1234_5641);
        chk("R11 space select high", 32'(mem_space), 1);
        reg_wr(2, 0);
        reg_rd(2, d);
        chk("R11 space select low", 32'(mem_space), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_full();
        t_wrap();
        t_ctx();
        t_busy();
        t_ctr();
        t_disable();
        t_head();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule